// File: doc/BRIEF.md
# Two-Way Bus Transceiver with Latch/Register Storage

The block moves 17-bit words between an A-side bus and a B-side bus, one storage element per direction. Each element runs in one of three modes: a transparent latch, a register that captures on the rising edge of that direction's data clock, or a hold in which nothing changes. Each direction has four controls: an active-low output enable, an active-low clock enable, an active-high latch enable and a data clock. The clock enable gates only the clocked path. Transparency takes priority over it.

The A side leaves the block as a three-state output: a data vector plus an enable vector. The B side is open drain. Each bit has a drive-low line and a release line, and a pull-up on the board supplies the high level. The A-to-B data clock is forwarded to the B side. A clock arriving on the B side is copied back to the A side.

The data clocks and controls are sampled by the block's own system clock, so all storage updates happen on that clock. A data-clock rising edge means the clock is seen low at one system edge and high at the next.

Top module: `bus_xcvr17`

## Requirements
- R1: While `oeAbN` is 1, every bit of `bRelease` is 1 and every bit of `bDriveLow` is 0. The A-to-B storage keeps updating, and the updated value appears once the enable returns to 0.
- R2: While `oeBaN` is 0, every bit of `aOutEn` is 1. While it is 1, every bit is 0. The B-to-A storage keeps updating either way.
- R3: While `leAb` is 1, the A-to-B value equals `aIn` in the same cycle, whatever `ceAbN` and `clkAb` do.
- R4: With `leAb` at 0 and `ceAbN` at 0, a system edge at which `clkAb` is 1, after it was 0 at the previous system edge, stores `aIn`. The new value appears after that edge.
- R5: With `leAb` at 0 and `ceAbN` at 1, edges of `clkAb` change nothing.
- R6: With `leAb` at 0 and `clkAb` held steady at either level, the stored value is kept while `aIn` changes.
- R7: When `leAb` falls, the value kept is the one present on `aIn` at the last system edge with `leAb` at 1. This holds even if `clkAb` is high at that moment.
- R8: Bit i of the A-to-B value is 0 exactly when `bDriveLow[i]` is 1, given the output is enabled. `bRelease` is always the complement of `bDriveLow`.
- R9: The B-to-A direction behaves like R3 to R7, using `leBa`, `ceBaN`, `clkBa` and `bIn`, with the value shown on `aOut`.
- R10: An asynchronous reset clears both stored words to zero. A data clock that is already high when reset ends does not count as a rising edge.
- R11: `clkFwdB` is a combinational copy of `clkAb`, and `aClkOut` is a combinational copy of `bClkIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples controls and data clocks |
| rstN | input | 1 | Asynchronous active-low reset |
| aIn | input | 17 | Word received from the A bus |
| aOut | output | 17 | Word presented to the A bus |
| aOutEn | output | 17 | Per-bit three-state enable for the A bus |
| bIn | input | 17 | Level sensed on the B bus |
| bDriveLow | output | 17 | Per-bit pull-down request on the B bus |
| bRelease | output | 17 | Per-bit release of the B bus |
| oeAbN | input | 1 | A-to-B output enable, active low |
| oeBaN | input | 1 | B-to-A output enable, active low |
| ceAbN | input | 1 | A-to-B clock enable, active low |
| ceBaN | input | 1 | B-to-A clock enable, active low |
| leAb | input | 1 | A-to-B latch enable, transparent when 1 |
| leBa | input | 1 | B-to-A latch enable, transparent when 1 |
| clkAb | input | 1 | A-to-B data clock |
| clkBa | input | 1 | B-to-A data clock |
| clkFwdB | output | 1 | Copy of clkAb sent to the B side |
| bClkIn | input | 1 | Clock received on the B side |
| aClkOut | output | 1 | Copy of bClkIn sent to the A side |

## Verification
Several properties are checked on every cycle: that a disabled output releases or floats its bus, that drive-low and release never overlap, that a transparent path shows its input, that a store happens only on a qualified edge, that the store takes the sampled input, and that the stored word is otherwise stable. Other behaviour needs a sequence of stimulus and can only be shown by the bench's scenarios. This includes the word held after the latch closes with the clock high, clock edges that are ignored while the clock enable is high, and a word captured while the output was disabled and seen after it is re-enabled. It also includes the rule that a clock already high at reset release is not an edge. The bench's reference model covers these by comparing against the design on every cycle.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  // Strobes from a direction's control to its datapath
  typedef struct packed {
    logic pass;   // show the input directly
    logic load;   // store the input at this system edge
    logic drive;  // output enabled
  } xcvrStrobes_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import bus_xcvr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         leIn,
  input  logic         ceN,
  input  logic         oeN,
  input  logic         portClk,
  output xcvrStrobes_t strb
);
  logic portClkPrev;
  logic portClkRise;

  // reset high: a clock already high at release is no edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) portClkPrev <= 1'b1;
    else       portClkPrev <= portClk;
  end

  assign portClkRise = portClk & ~portClkPrev;

  always_comb begin
    strb.pass  = leIn;
    strb.load  = leIn | (~ceN & portClkRise);
    strb.drive = ~oeN;
  end

  // R4/R5: outside transparency a store needs an enabled low-to-high clock
  assert_qualified_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !leIn) |-> (!ceN && portClk && !$past(portClk)));
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import bus_xcvr_pkg::*;
#(
  parameter int WIDTH = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  input  xcvrStrobes_t     strb,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] storeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          storeQ <= '0;
    else if (strb.load) storeQ <= din;
  end

  assign dout = strb.pass ? din : storeQ;

  // R6: without a load strobe the stored word does not move
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(storeQ));
  // R4: a load keeps the word sampled at that edge
  assert_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> storeQ == $past(din));
endmodule

// File: rtl/bus_xcvr17.sv
module bus_xcvr17
  import bus_xcvr_pkg::*;
#(
  parameter int WIDTH = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] aOutEn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bDriveLow,
  output logic [WIDTH-1:0] bRelease,
  input  logic             oeAbN,
  input  logic             oeBaN,
  input  logic             ceAbN,
  input  logic             ceBaN,
  input  logic             leAb,
  input  logic             leBa,
  input  logic             clkAb,
  input  logic             clkBa,
  output logic             clkFwdB,
  input  logic             bClkIn,
  output logic             aClkOut
);
  xcvrStrobes_t     strbAb, strbBa;
  logic [WIDTH-1:0] abData, baData;

  xcvr_ctrl u_ctrlAb (.clk(clk), .rstN(rstN), .leIn(leAb), .ceN(ceAbN),
                      .oeN(oeAbN), .portClk(clkAb), .strb(strbAb));
  xcvr_path #(.WIDTH(WIDTH)) u_pathAb (.clk(clk), .rstN(rstN), .din(aIn),
                      .strb(strbAb), .dout(abData));

  xcvr_ctrl u_ctrlBa (.clk(clk), .rstN(rstN), .leIn(leBa), .ceN(ceBaN),
                      .oeN(oeBaN), .portClk(clkBa), .strb(strbBa));
  xcvr_path #(.WIDTH(WIDTH)) u_pathBa (.clk(clk), .rstN(rstN), .din(bIn),
                      .strb(strbBa), .dout(baData));

  // open-drain B side: pull low for a 0 bit, release otherwise
  assign bDriveLow = {WIDTH{strbAb.drive}} & ~abData;
  assign bRelease  = ~bDriveLow;
  // three-state A side
  assign aOut    = baData;
  assign aOutEn  = {WIDTH{strbBa.drive}};
  assign clkFwdB = clkAb;
  assign aClkOut = bClkIn;

  assert_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    oeAbN |-> (&bRelease && bDriveLow == '0));
  assert_floated_R2: assert property (@(posedge clk) disable iff (!rstN)
    oeBaN |-> aOutEn == '0);
  assert_pass_R3: assert property (@(posedge clk) disable iff (!rstN)
    (leAb && !oeAbN) |-> bRelease == aIn);
  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bDriveLow & bRelease) == '0);
  assert_pass_R9: assert property (@(posedge clk) disable iff (!rstN)
    leBa |-> aOut == bIn);
  assert_forward_R11: assert property (@(posedge clk) disable iff (!rstN)
    clkFwdB == clkAb && aClkOut == bClkIn);
endmodule

// File: tb/bus_xcvr17_tb.sv
module bus_xcvr17_tb;
  localparam int W = 17;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aIn = '0, extB = '1;
  logic [W-1:0] aOut, aOutEn, bIn, bDriveLow, bRelease;
  logic oeAbN = 1'b0, oeBaN = 1'b0, ceAbN = 1'b0, ceBaN = 1'b0;
  logic leAb = 1'b0, leBa = 1'b0, clkAb = 1'b1, clkBa = 1'b1, bClkIn = 1'b0;
  logic clkFwdB, aClkOut;
  int checks = 0, errors = 0;
  string curReq = "R10";

  always #5 clk = ~clk;

  // B bus: pull-up, wired-AND with an external driver and the block
  assign bIn = extB & bRelease;

  bus_xcvr17 u_dut (.clk(clk), .rstN(rstN), .aIn(aIn), .aOut(aOut), .aOutEn(aOutEn),
    .bIn(bIn), .bDriveLow(bDriveLow), .bRelease(bRelease), .oeAbN(oeAbN), .oeBaN(oeBaN),
    .ceAbN(ceAbN), .ceBaN(ceBaN), .leAb(leAb), .leBa(leBa), .clkAb(clkAb), .clkBa(clkBa),
    .clkFwdB(clkFwdB), .bClkIn(bClkIn), .aClkOut(aClkOut));

  // behavioural reference: last stored word and last seen clock level
  logic [W-1:0] mAb, mBa;
  logic lastAb, lastBa;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAb <= '0; mBa <= '0; lastAb <= 1'b1; lastBa <= 1'b1;
    end else begin
      if (leAb || (!ceAbN && clkAb && !lastAb)) mAb <= aIn;
      if (leBa || (!ceBaN && clkBa && !lastBa)) mBa <= bIn;
      lastAb <= clkAb;
      lastBa <= clkBa;
    end
  end

  task automatic compare();
    logic [W-1:0] abVal, expDl, expA, expEn;
    abVal = leAb ? aIn : mAb;
    expDl = oeAbN ? '0 : ~abVal;
    expA  = leBa ? bIn : mBa;
    expEn = oeBaN ? '0 : '1;
    checks++;
    if (bDriveLow !== expDl || bRelease !== ~expDl) begin
      errors++;
      $display("FAIL %s bDriveLow=%h bRelease=%h expected %h/%h", curReq,
               bDriveLow, bRelease, expDl, ~expDl);
    end
    checks++;
    if (aOut !== expA || aOutEn !== expEn) begin
      errors++;
      $display("FAIL %s aOut=%h aOutEn=%h expected %h/%h", curReq, aOut, aOutEn, expA, expEn);
    end
    checks++;
    if (clkFwdB !== clkAb || aClkOut !== bClkIn) begin
      errors++;
      $display("FAIL R11 clkFwdB=%b aClkOut=%b expected %b/%b", clkFwdB, aClkOut, clkAb, bClkIn);
    end
  endtask

  // inputs change at the falling edge; compare after they settle
  task automatic step();
    #1 compare();
    @(negedge clk);
  endtask

  task automatic expectWord(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s value=%h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    // R10: reset clears storage; clocks held high at release are no edge
    aIn = 17'h1A5A5; extB = 17'h0F0F0;
    repeat (3) @(negedge clk);
    compare();
    rstN = 1'b1;
    repeat (4) step();
    expectWord("R10", bDriveLow, '1);
    bClkIn = 1'b1; step();

    // R3: transparency whatever clock and clock enable do
    curReq = "R3"; leAb = 1'b1;
    for (int i = 0; i < 12; i++) begin
      aIn = 17'($urandom); clkAb = ~clkAb; ceAbN = 1'($urandom);
      step();
    end
    // R7: latch closes with clock high, later input change is ignored
    curReq = "R7"; clkAb = 1'b1; aIn = 17'h12345; step();
    leAb = 1'b0; aIn = 17'h0AAAA;
    repeat (3) step();
    expectWord("R7", ~bDriveLow, 17'h12345);

    // R4: clocked capture
    curReq = "R4"; ceAbN = 1'b0;
    for (int i = 0; i < 16; i++) begin
      aIn = 17'($urandom); clkAb = ~clkAb;
      step();
    end
    // R6: clock steady low, then steady high
    curReq = "R6"; clkAb = 1'b0; step(); held = ~bDriveLow;
    for (int i = 0; i < 6; i++) begin aIn = 17'($urandom); step(); end
    clkAb = 1'b1; step(); held = ~bDriveLow;
    for (int i = 0; i < 6; i++) begin aIn = 17'($urandom); step(); end
    expectWord("R6", ~bDriveLow, held);

    // R5: clock inhibit
    curReq = "R5"; ceAbN = 1'b1;
    for (int i = 0; i < 10; i++) begin aIn = 17'($urandom); clkAb = ~clkAb; step(); end
    expectWord("R5", ~bDriveLow, held);
    ceAbN = 1'b0;

    // R1: disabled output, storage still captures
    curReq = "R1"; oeAbN = 1'b1; clkAb = 1'b0; step();
    aIn = 17'h00F0F; clkAb = 1'b1; step();
    aIn = 17'h1FFFF; step();
    expectWord("R1", bRelease, '1);
    oeAbN = 1'b0; step();
    expectWord("R1", ~bDriveLow, 17'h00F0F);

    // R8: open-drain encoding over varied patterns
    curReq = "R8"; leAb = 1'b1;
    aIn = 17'h00000; step(); aIn = 17'h1FFFF; step();
    aIn = 17'h15555; step(); aIn = 17'h0AAAA; step();
    leAb = 1'b0;

    // R9 and R2: B-to-A mirror
    curReq = "R9"; oeAbN = 1'b1; leBa = 1'b1;
    for (int i = 0; i < 8; i++) begin extB = 17'($urandom); clkBa = ~clkBa; step(); end
    clkBa = 1'b1; extB = 17'h0C3C3; step();
    leBa = 1'b0; extB = 17'h13C3C; step();
    expectWord("R9", aOut, 17'h0C3C3);
    ceBaN = 1'b0;
    for (int i = 0; i < 12; i++) begin extB = 17'($urandom); clkBa = ~clkBa; step(); end
    ceBaN = 1'b1;
    for (int i = 0; i < 8; i++) begin extB = 17'($urandom); clkBa = ~clkBa; step(); end
    curReq = "R2"; oeBaN = 1'b1; ceBaN = 1'b0; clkBa = 1'b0; step();
    extB = 17'h05A5A; clkBa = 1'b1; step();
    expectWord("R2", aOutEn, '0);
    extB = 17'h1FFFF; oeBaN = 1'b0; step();
    expectWord("R2", aOut, 17'h05A5A);
    bClkIn = 1'b0; step();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule